// File: doc/BRIEF.md
# Privilege-Qualified Address Breakpoint Comparator

This block watches a hart's instruction fetches and data accesses and decides, every cycle, whether any of a bank of address triggers should stop the hart with a breakpoint exception. Each trigger has a control word and a compare address. The control word has two groups of enable bits. One group selects the privilege levels in which the trigger may fire. The other selects the kinds of access it watches: instruction execute, data load and data store.

All triggers are evaluated in parallel. An execute trigger is compared against the fetch PC. Load and store triggers are compared against the data access address. The comparison is an exact 32-bit equality. When any trigger hits, the block raises a breakpoint request. That request is meant to be acted on before the matching instruction retires or the matching access commits. The block also reports the index of the lowest-numbered trigger that hit.

Results are registered. The hit flag, hit index and exception request appear on the clock edge that follows the cycle in which the qualifying fetch or access was presented.

Top module: `brk_match_unit`

## Requirements
- R1: While reset is held, and on the first edge after it, `hit_o` and `brk_req_o` are 0, and `hit_idx_o` and `brk_cause_o` are all zeros.
- R2: A trigger can fire only when it is armed. Armed means at least one of its privilege bits (control bits 3, 4, 6) is set and at least one of its access bits (bit 0 load, bit 1 store, bit 2 execute) is set. A trigger that lacks either group never fires.
- R3: A trigger fires only if control bit (3 + `priv_i`) is set. The `priv_i` encoding is user 0, supervisor 1, machine 3; value 2 tests bit 5.
- R4: A trigger with bit 2 set fires when `fetch_valid_i` is 1 and `fetch_pc_i` equals its compare address.
- R5: A trigger with bit 0 set fires when `mem_load_i` is 1 and `mem_addr_i` equals its compare address. A store alone does not fire it.
- R6: A trigger with bit 1 set fires when `mem_store_i` is 1 and the addresses match. A trigger with both bits 0 and 1 set fires on either access kind.
- R7: When several triggers hit in one cycle, `hit_idx_o` reports the lowest index. It reads 0 when there is no hit.
- R8: `hit_o` and `brk_req_o` rise for exactly the cycle after a qualifying fetch or access, and fall back when the next cycle has no hit. While the request is high, `brk_cause_o` is 3; otherwise it is 0. Nothing fires while all strobes are low.
- R9: The match is exact equality over all 32 address bits. The size field (control bits 16 and 17) does not widen it, so an address one byte off never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_ctrl_i | input | NUM_TRIG*CTRL_W | Control words, trigger k in slice k |
| trig_addr_i | input | NUM_TRIG*ADDR_W | Compare addresses, trigger k in slice k |
| priv_i | input | 2 | Current privilege level |
| fetch_valid_i | input | 1 | Fetch PC is valid this cycle |
| fetch_pc_i | input | ADDR_W | Fetch PC |
| mem_load_i | input | 1 | Load access this cycle |
| mem_store_i | input | 1 | Store access this cycle |
| mem_addr_i | input | ADDR_W | Data access address |
| hit_o | output | 1 | A trigger hit in the previous cycle |
| hit_idx_o | output | IDX_W | Lowest hitting trigger index |
| brk_req_o | output | 1 | Breakpoint exception request |
| brk_cause_o | output | 4 | Exception cause, 3 while requesting |

## Verification
The hardest situation to reach is a cycle in which several triggers hit at once through different paths. For example, one trigger matches on the fetch path and another on the data path, under a privilege level that only some of them permit. Reaching it needs aligned addresses and strobes together. The stimulus first places triggers on a shared address on purpose. It then runs a randomized phase that draws addresses, strobes and privilege from small pools, so that coincident hits, near-miss addresses and partly armed controls occur often. Every cycle is compared against a behavioural model.

// File: rtl/brk_pkg.sv
package brk_pkg;
    // control-word bit positions
    localparam int unsigned B_LOAD  = 0;
    localparam int unsigned B_STORE = 1;
    localparam int unsigned B_EXEC  = 2;
    localparam int unsigned B_PRIV0 = 3;  // privilege enable = B_PRIV0 + level
    localparam int unsigned B_USER  = 3;
    localparam int unsigned B_SUPV  = 4;
    localparam int unsigned B_MACH  = 6;
    localparam int unsigned MIN_CTRL_W = 7;

    localparam int unsigned CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_BRK = 4'd3;

    typedef struct packed {
        logic ld;
        logic st;
        logic ex;
    } acc_kind_t;
endpackage

// File: rtl/brk_trig_cmp.sv
module brk_trig_cmp
    import brk_pkg::*;
#(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [ADDR_W-1:0] cmp_addr_i,
    input  logic [1:0]        priv_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              mem_load_i,
    input  logic              mem_store_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    output logic              hit_o
);
    acc_kind_t kind;
    logic      any_priv;
    logic      any_kind;
    logic      priv_ok;
    logic      ex_hit;
    logic      mem_hit;

    always_comb begin
        kind.ld  = ctrl_i[B_LOAD];
        kind.st  = ctrl_i[B_STORE];
        kind.ex  = ctrl_i[B_EXEC];
        any_priv = ctrl_i[B_USER] | ctrl_i[B_SUPV] | ctrl_i[B_MACH];
        any_kind = kind.ld | kind.st | kind.ex;
        case (priv_i)
            2'd0:    priv_ok = ctrl_i[B_PRIV0 + 0];
            2'd1:    priv_ok = ctrl_i[B_PRIV0 + 1];
            2'd2:    priv_ok = ctrl_i[B_PRIV0 + 2];
            default: priv_ok = ctrl_i[B_PRIV0 + 3];
        endcase
        ex_hit  = kind.ex & fetch_valid_i & (fetch_pc_i == cmp_addr_i);
        mem_hit = ((kind.ld & mem_load_i) | (kind.st & mem_store_i))
                  & (mem_addr_i == cmp_addr_i);
        hit_o   = any_priv & any_kind & priv_ok & (ex_hit | mem_hit);
    end
endmodule

// File: rtl/brk_prio_enc.sv
module brk_prio_enc #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) idx_o = IW'(k);
        end
    end
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
#(
    parameter int unsigned NUM_TRIG = 4,
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned ADDR_W   = 32,
    localparam int unsigned IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_TRIG*CTRL_W-1:0]   trig_ctrl_i,
    input  logic [NUM_TRIG*ADDR_W-1:0]   trig_addr_i,
    input  logic [1:0]                   priv_i,
    input  logic                         fetch_valid_i,
    input  logic [ADDR_W-1:0]            fetch_pc_i,
    input  logic                         mem_load_i,
    input  logic                         mem_store_i,
    input  logic [ADDR_W-1:0]            mem_addr_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             hit_idx_o,
    output logic                         brk_req_o,
    output logic [CAUSE_W-1:0]           brk_cause_o
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             req;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_TRIG-1:0] trig_hit;
    logic                any_hit;
    logic [IDX_W-1:0]    first_idx;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        brk_trig_cmp #(
            .CTRL_W(CTRL_W),
            .ADDR_W(ADDR_W)
        ) u_cmp (
            .ctrl_i       (trig_ctrl_i[g*CTRL_W +: CTRL_W]),
            .cmp_addr_i   (trig_addr_i[g*ADDR_W +: ADDR_W]),
            .priv_i       (priv_i),
            .fetch_valid_i(fetch_valid_i),
            .fetch_pc_i   (fetch_pc_i),
            .mem_load_i   (mem_load_i),
            .mem_store_i  (mem_store_i),
            .mem_addr_i   (mem_addr_i),
            .hit_o        (trig_hit[g])
        );
    end

    brk_prio_enc #(
        .N(NUM_TRIG)
    ) u_prio (
        .req_i(trig_hit),
        .any_o(any_hit),
        .idx_o(first_idx)
    );

    always_comb begin
        state_d     = '0;
        state_d.hit = any_hit;
        state_d.req = any_hit;
        state_d.idx = any_hit ? first_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hit_o       = state_q.hit;
    assign hit_idx_o   = state_q.idx;
    assign brk_req_o   = state_q.req;
    assign brk_cause_o = state_q.req ? CAUSE_BRK : '0;
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk
    import brk_pkg::*;
#(
    parameter int unsigned NUM_TRIG = 4,
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned ADDR_W   = 32,
    localparam int unsigned IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_TRIG*CTRL_W-1:0] trig_ctrl_i,
    input logic                       fetch_valid_i,
    input logic                       mem_load_i,
    input logic                       mem_store_i,
    input logic                       hit_o,
    input logic [IDX_W-1:0]           hit_idx_o,
    input logic                       brk_req_o,
    input logic [CAUSE_W-1:0]         brk_cause_o
);
    logic any_armed;
    logic any_strobe;

    always_comb begin
        any_armed = 1'b0;
        for (int k = 0; k < NUM_TRIG; k++) begin
            if ((trig_ctrl_i[k*CTRL_W + B_USER] | trig_ctrl_i[k*CTRL_W + B_SUPV]
                 | trig_ctrl_i[k*CTRL_W + B_MACH])
                && (trig_ctrl_i[k*CTRL_W + B_LOAD] | trig_ctrl_i[k*CTRL_W + B_STORE]
                 | trig_ctrl_i[k*CTRL_W + B_EXEC]))
                any_armed = 1'b1;
        end
        any_strobe = fetch_valid_i | mem_load_i | mem_store_i;
    end

    // R8
    cause_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> (brk_cause_o == CAUSE_BRK));
    // R8
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req_o |-> (brk_cause_o == '0));
    // R8
    req_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> $past(any_strobe));
    // R2
    req_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req_o |-> $past(any_armed));
    // R8
    hit_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == brk_req_o);
    // R7
    idx_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_idx_o == '0));
endmodule

bind brk_match_unit brk_match_chk #(
    .NUM_TRIG(NUM_TRIG),
    .CTRL_W  (CTRL_W),
    .ADDR_W  (ADDR_W)
) u_brk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_ctrl_i  (trig_ctrl_i),
    .fetch_valid_i(fetch_valid_i),
    .mem_load_i   (mem_load_i),
    .mem_store_i  (mem_store_i),
    .hit_o        (hit_o),
    .hit_idx_o    (hit_idx_o),
    .brk_req_o    (brk_req_o),
    .brk_cause_o  (brk_cause_o)
);

// File: tb/tb_brk_match_unit.sv
module tb_brk_match_unit;
    localparam int NT = 4;
    localparam int CW = 32;
    localparam int AW = 32;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [CW-1:0]   ctrl [NT];
    logic [AW-1:0]   cadr [NT];
    logic [NT*CW-1:0] ctrl_bus;
    logic [NT*AW-1:0] addr_bus;
    logic [1:0]      priv;
    logic            fv, ld, st;
    logic [AW-1:0]   pc, maddr;
    logic            hit, req;
    logic [IW-1:0]   idx;
    logic [3:0]      cause;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    for (genvar g = 0; g < NT; g++) begin : g_pack
        assign ctrl_bus[g*CW +: CW] = ctrl[g];
        assign addr_bus[g*AW +: AW] = cadr[g];
    end

    brk_match_unit #(.NUM_TRIG(NT), .CTRL_W(CW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_ctrl_i(ctrl_bus), .trig_addr_i(addr_bus),
        .priv_i(priv), .fetch_valid_i(fv), .fetch_pc_i(pc), .mem_load_i(ld),
        .mem_store_i(st), .mem_addr_i(maddr), .hit_o(hit), .hit_idx_o(idx),
        .brk_req_o(req), .brk_cause_o(cause)
    );

    // behavioural reference: returns -1 for no hit, else first hitting index
    function automatic int model();
        int hidx = -1;
        for (int t = NT - 1; t >= 0; t--) begin
            bit pr   = ctrl[t][3] || ctrl[t][4] || ctrl[t][6];
            bit kd   = ctrl[t][0] || ctrl[t][1] || ctrl[t][2];
            bit lvl  = ctrl[t][3 + int'(priv)];
            bit exm  = ctrl[t][2] && fv && (pc == cadr[t]);
            bit ldm  = ctrl[t][0] && ld && (maddr == cadr[t]);
            bit stm  = ctrl[t][1] && st && (maddr == cadr[t]);
            if (pr && kd && lvl && (exm || ldm || stm)) hidx = t;
        end
        if (!rst_n) hidx = -1;
        return hidx;
    endfunction

    task automatic tick(input string tag);
        int e = model();
        bit eh = (e >= 0);
        logic [IW-1:0] ei = eh ? IW'(e) : '0;
        logic [3:0] ec = eh ? 4'd3 : 4'd0;
        @(posedge clk);
        #2;
        tests++;
        if (hit !== eh || req !== eh || idx !== ei || cause !== ec) begin
            fails++;
            $display("FAIL %s: hit=%b req=%b idx=%0d cause=%0d expected hit=%b req=%b idx=%0d cause=%0d",
                     tag, hit, req, idx, cause, eh, eh, ei, ec);
        end
    endtask

    task automatic idle();
        fv = 0; ld = 0; st = 0; pc = '0; maddr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) begin ctrl[t] = '0; cadr[t] = '0; end
        priv = 2'd3; idle();
        rst_n = 0;
        fv = 1; pc = 32'h0;  // strobe active during reset must not fire
        ctrl[0] = 32'h44;
        tick("R1"); tick("R1");
        #1 rst_n = 1; idle();
        tick("R1");

        // R4 execute match in machine mode
        ctrl[0] = 32'h44; cadr[0] = 32'h0000_1000;
        fv = 1; pc = 32'h0000_1000; tick("R4");
        idle(); tick("R8");             // pulse falls back
        // R3 user mode not enabled
        priv = 2'd0; fv = 1; pc = 32'h0000_1000; tick("R3");
        priv = 2'd2; tick("R3");
        ctrl[0] = 32'h64; tick("R3");   // bit 5 enables level 2
        priv = 2'd3;
        // R9 one byte off, size bits set
        ctrl[0] = 32'h0003_0044; pc = 32'h0000_1001; tick("R9");
        pc = 32'h8000_1000; tick("R9");
        pc = 32'h0000_1000; tick("R9");
        // R8 strobe low
        fv = 0; tick("R8");
        // R2 disarmed
        ctrl[0] = 32'h04; fv = 1; tick("R2");
        ctrl[0] = 32'h48; tick("R2");
        idle(); ctrl[0] = '0;

        // R5 load trigger on index 1, user mode
        priv = 2'd0; ctrl[1] = 32'h09; cadr[1] = 32'h0000_2000;
        ld = 1; maddr = 32'h0000_2000; tick("R5");
        ld = 0; st = 1; tick("R5");
        st = 0; fv = 1; pc = 32'h0000_2000; tick("R5");
        idle(); ctrl[1] = '0;

        // R6 store trigger on index 2, supervisor
        priv = 2'd1; ctrl[2] = 32'h12; cadr[2] = 32'h0000_3000;
        st = 1; maddr = 32'h0000_3000; tick("R6");
        st = 0; ld = 1; tick("R6");
        ctrl[2] = 32'h13; tick("R6");
        ld = 0; st = 1; tick("R6");
        idle();

        // R7 several hits: lowest index wins
        priv = 2'd3;
        ctrl[1] = 32'h41; cadr[1] = 32'h0000_4000;
        ctrl[3] = 32'h41; cadr[3] = 32'h0000_4000;
        ctrl[2] = 32'h44; cadr[2] = 32'h0000_5000;
        ld = 1; maddr = 32'h0000_4000; fv = 1; pc = 32'h0000_5000; tick("R7");
        ld = 0; tick("R7");
        ld = 1; fv = 0; ctrl[1] = '0; tick("R7");
        idle(); tick("R7");

        // randomized mix
        for (int n = 0; n < 400; n++) begin
            for (int t = 0; t < NT; t++) begin
                ctrl[t] = 32'($urandom) & 32'h0003_007F;
                cadr[t] = 32'h100 + 32'($urandom_range(0, 3));
            end
            priv  = 2'($urandom);
            fv    = 1'($urandom);
            ld    = 1'($urandom);
            st    = 1'($urandom);
            pc    = 32'h100 + 32'($urandom_range(0, 4));
            maddr = 32'h100 + 32'($urandom_range(0, 4));
            tick("R7");
        end
        idle(); tick("R8");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule